// File: doc/BRIEF.md
# Delimiter-Gated Repeater Bit Buffer

This block sits between a recovered serial bit stream arriving from a shared backplane bus and the local transmit path of a repeater port. The incoming stream is NRZ data with its own sampling clock and a qualifying enable. A hunter watches the bits for the start-of-frame delimiter. It throws away the preamble and the delimiter, and writes only the bits that follow into a small one-bit-wide FIFO.

The FIFO crosses into the local transmit clock through Gray-coded pointers. Reading is held back until the local transmitter has been sending preamble for a minimum number of bit times and the repeater control logic grants readiness. After that, one stored bit leaves per transmit clock. The empty flag lets the control state machine see when the frame has fully drained, and only then is repetition finished. A sticky overflow flag records any bit lost because the FIFO was full.

Top module: `sfd_elastic_buf`

## Requirements
- R1: After reset, tx_empty is 1, tx_valid is 0 and rx_ovf is 0.
- R2: Bits are sampled on rising rx_clk while rx_en is 1. The delimiter is found when a 1 follows a 1 that closed an unbroken run of alternating bits, and that run, counting that first 1, is at least SFD_MIN_RUN bits long. With the default of 6, a run of exactly 6 is accepted and a run of 5 is not.
- R3: Neither preamble bits nor the two delimiter bits are ever stored. Only bits sampled after the delimiter enter the FIFO.
- R4: Stored bits leave on tx_bit in arrival order, one per tx_clk cycle while reading is allowed, each marked by tx_valid high for that cycle.
- R5: Reading starts only after tx_active has been high for PRE_MIN rising tx_clk edges. Counting from the first edge that samples tx_active high, with tx_ready high and data present, tx_valid is first seen after edge PRE_MIN+1 and not after edge PRE_MIN.
- R6: While tx_ready is 0, no bit is read, and stored bits stay in the FIFO.
- R7: Once every stored bit has been read, tx_empty is 1 and tx_valid is 0.
- R8: When rx_en goes low, the delimiter lock is lost. Bits sampled later are not stored until a new delimiter is found, while bits already stored still drain in order.
- R9: A bit that arrives while DEPTH bits are held is dropped and rx_ovf is set. rx_ovf stays set until rx reset, and the first DEPTH bits still read out intact.
- R10: Exactly DEPTH (default 32) bits fit without setting rx_ovf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Bit clock of the incoming serial stream |
| rx_rst_n | input | 1 | Active-low reset, receive side |
| rx_en | input | 1 | Qualifies rx_data as a valid bit |
| rx_data | input | 1 | Incoming NRZ bit |
| rx_ovf | output | 1 | Sticky flag: a bit was dropped because the FIFO was full |
| tx_clk | input | 1 | Local transmit bit clock |
| tx_rst_n | input | 1 | Active-low reset, transmit side |
| tx_active | input | 1 | High while the local transmitter is sending (preamble first) |
| tx_ready | input | 1 | Read permission from the repeater control logic |
| tx_bit | output | 1 | Bit read out of the FIFO |
| tx_valid | output | 1 | tx_bit carries a stored bit this cycle |
| tx_empty | output | 1 | No stored bits remain to be read |

## Verification
The assertions assume that the two clocks are independent and that each reset is held across several edges of its own clock. They also assume that rx_data and rx_en change only away from the rising rx_clk edge, and tx_active and tx_ready only away from the rising tx_clk edge. The bench drives every input on the falling edge of its own clock, and it releases both resets together after holding them for several cycles. It waits for the pointer synchronisers to settle before it judges tx_empty or the read results.

// File: rtl/sfd_eb_pkg.sv
`timescale 1ns/1ps
package sfd_eb_pkg;

    typedef enum logic {
        HUNT_SEEK = 1'b0,
        HUNT_LOCK = 1'b1
    } hunt_e;

endpackage

// File: rtl/eb_gray_sync.sv
`timescale 1ns/1ps
module eb_gray_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= st_d[i];
        end
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sfd_hunt.sv
`timescale 1ns/1ps
module sfd_hunt
    import sfd_eb_pkg::*;
#(
    parameter int MIN_RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic bit_i,
    output logic wr_req_o,
    output logic wr_bit_o
);
    localparam int RUN_W = $clog2(MIN_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(MIN_RUN);

    typedef struct packed {
        hunt_e            st;
        logic             prev;
        logic [RUN_W-1:0] run;
    } hunt_s;

    hunt_s hunt_d, hunt_q;

    always_comb begin
        hunt_d   = hunt_q;
        wr_req_o = 1'b0;
        if (!en_i) begin
            hunt_d.st  = HUNT_SEEK;
            hunt_d.run = '0;
        end else if (hunt_q.st == HUNT_LOCK) begin
            wr_req_o = 1'b1;
        end else begin
            hunt_d.prev = bit_i;
            if (hunt_q.run == '0) begin
                hunt_d.run = RUN_W'(1);
            end else if (bit_i != hunt_q.prev) begin
                hunt_d.run = (hunt_q.run == RUN_SAT) ? hunt_q.run : hunt_q.run + 1'b1;
            end else if (bit_i && hunt_q.prev && (hunt_q.run >= RUN_SAT)) begin
                hunt_d.st  = HUNT_LOCK;
                hunt_d.run = '0;
            end else begin
                hunt_d.run = RUN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hunt_q <= hunt_s'(0);
        else        hunt_q <= hunt_d;
    end

    assign wr_bit_o = bit_i;

    // R8
    en_drop_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !wr_req_o);

    // R3
    seek_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hunt_q.st == HUNT_SEEK) |-> !wr_req_o);
endmodule

// File: rtl/eb_wr_side.sv
`timescale 1ns/1ps
module eb_wr_side #(
    parameter int AW = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_req_i,
    input  logic [AW:0] rd_gray_sync_i,
    output logic        wr_do_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [AW:0] wr_gray_o,
    output logic        ovf_o
);
    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
        logic        ovf;
    } wr_s;

    wr_s  wr_d, wr_q;
    logic full;
    logic [AW:0] bin_inc;

    assign full    = (wr_q.gray == {~rd_gray_sync_i[AW:AW-1], rd_gray_sync_i[AW-2:0]});
    assign bin_inc = wr_q.bin + 1'b1;

    always_comb begin
        wr_d    = wr_q;
        wr_do_o = wr_req_i && !full;
        if (wr_do_o) begin
            wr_d.bin  = bin_inc;
            wr_d.gray = bin_inc ^ (bin_inc >> 1);
        end
        if (wr_req_i && full) begin
            wr_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    assign wr_addr_o = wr_q.bin[AW-1:0];
    assign wr_gray_o = wr_q.gray;
    assign ovf_o     = wr_q.ovf;

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && full) |=> $stable(wr_q.bin));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
endmodule

// File: rtl/eb_rd_side.sv
`timescale 1ns/1ps
module eb_rd_side #(
    parameter int AW      = 5,
    parameter int PRE_MIN = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic          ready_i,
    input  logic [AW:0]   wr_gray_sync_i,
    input  logic          mem_bit_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [AW:0]   rd_gray_o,
    output logic          tx_bit_o,
    output logic          tx_valid_o,
    output logic          tx_empty_o
);
    localparam int PCW = $clog2(PRE_MIN + 1);
    localparam logic [PCW-1:0] PRE_LIM = PCW'(PRE_MIN);

    typedef struct packed {
        logic [AW:0]    bin;
        logic [AW:0]    gray;
        logic [PCW-1:0] pre_cnt;
        logic           bit_out;
        logic           valid;
    } rd_s;

    rd_s  rd_d, rd_q;
    logic empty, go, rd_en;
    logic [AW:0] bin_inc;

    assign empty   = (rd_q.gray == wr_gray_sync_i);
    assign go      = (rd_q.pre_cnt == PRE_LIM) && ready_i;
    assign rd_en   = go && !empty;
    assign bin_inc = rd_q.bin + 1'b1;

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_en;
        if (!active_i)               rd_d.pre_cnt = '0;
        else if (rd_q.pre_cnt != PRE_LIM) rd_d.pre_cnt = rd_q.pre_cnt + 1'b1;
        if (rd_en) begin
            rd_d.bit_out = mem_bit_i;
            rd_d.bin     = bin_inc;
            rd_d.gray    = bin_inc ^ (bin_inc >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_addr_o  = rd_q.bin[AW-1:0];
    assign rd_gray_o  = rd_q.gray;
    assign tx_bit_o   = rd_q.bit_out;
    assign tx_valid_o = rd_q.valid;
    assign tx_empty_o = empty;

    // R5
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q.pre_cnt != PRE_LIM) |=> !tx_valid_o);

    // R6
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> !tx_valid_o);

    // R7
    empty_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> !tx_valid_o);

    // R4
    read_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> (rd_q.bin != $past(rd_q.bin)));
endmodule

// File: rtl/sfd_elastic_buf.sv
`timescale 1ns/1ps
module sfd_elastic_buf #(
    parameter int DEPTH       = 32,
    parameter int SFD_MIN_RUN = 6,
    parameter int PRE_MIN     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic rx_clk,
    input  logic rx_rst_n,
    input  logic rx_en,
    input  logic rx_data,
    output logic rx_ovf,
    input  logic tx_clk,
    input  logic tx_rst_n,
    input  logic tx_active,
    input  logic tx_ready,
    output logic tx_bit,
    output logic tx_valid,
    output logic tx_empty
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_req, wr_bit, wr_do;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [AW:0]   wr_gray, rd_gray, wr_gray_tx, rd_gray_rx;
    logic          mem_q [DEPTH];

    sfd_hunt #(.MIN_RUN(SFD_MIN_RUN)) hunt_i (
        .clk(rx_clk), .rst_n(rx_rst_n), .en_i(rx_en), .bit_i(rx_data),
        .wr_req_o(wr_req), .wr_bit_o(wr_bit)
    );

    eb_wr_side #(.AW(AW)) wr_i (
        .clk(rx_clk), .rst_n(rx_rst_n), .wr_req_i(wr_req),
        .rd_gray_sync_i(rd_gray_rx), .wr_do_o(wr_do), .wr_addr_o(wr_addr),
        .wr_gray_o(wr_gray), .ovf_o(rx_ovf)
    );

    always_ff @(posedge rx_clk) begin
        if (wr_do) mem_q[wr_addr] <= wr_bit;
    end

    eb_gray_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) w2r_i (
        .clk(tx_clk), .rst_n(tx_rst_n), .d_i(wr_gray), .q_o(wr_gray_tx)
    );

    eb_gray_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) r2w_i (
        .clk(rx_clk), .rst_n(rx_rst_n), .d_i(rd_gray), .q_o(rd_gray_rx)
    );

    eb_rd_side #(.AW(AW), .PRE_MIN(PRE_MIN)) rd_i (
        .clk(tx_clk), .rst_n(tx_rst_n), .active_i(tx_active), .ready_i(tx_ready),
        .wr_gray_sync_i(wr_gray_tx), .mem_bit_i(mem_q[rd_addr]),
        .rd_addr_o(rd_addr), .rd_gray_o(rd_gray), .tx_bit_o(tx_bit),
        .tx_valid_o(tx_valid), .tx_empty_o(tx_empty)
    );
endmodule

// File: tb/sfd_elastic_buf_tb_top.sv
`timescale 1ns/1ps
module sfd_elastic_buf_tb_top;
    localparam int DEPTH   = 32;
    localparam int MINRUN  = 6;
    localparam int PREMIN  = 16;

    logic rx_clk = 0, tx_clk = 0;
    logic rx_rst_n = 0, tx_rst_n = 0;
    logic rx_en = 0, rx_data = 0, tx_active = 0, tx_ready = 0;
    logic rx_ovf, tx_bit, tx_valid, tx_empty;

    int n_chk = 0, n_bad = 0;
    logic got [64];
    int   got_n = 0;
    logic exp_b [64];
    int   exp_n = 0;

    always #5 tx_clk = ~tx_clk;
    always #7 rx_clk = ~rx_clk;

    sfd_elastic_buf #(.DEPTH(DEPTH), .SFD_MIN_RUN(MINRUN), .PRE_MIN(PREMIN)) dut_i (
        .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_en(rx_en), .rx_data(rx_data),
        .rx_ovf(rx_ovf), .tx_clk(tx_clk), .tx_rst_n(tx_rst_n),
        .tx_active(tx_active), .tx_ready(tx_ready), .tx_bit(tx_bit),
        .tx_valid(tx_valid), .tx_empty(tx_empty)
    );

    always @(negedge tx_clk) begin
        if (tx_valid && got_n < 64) begin
            got[got_n] = tx_bit;
            got_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic pat(input int i, input int s);
        logic [7:0] v;
        v = 8'(i * s + (i >> 1) + s);
        return ^v;
    endfunction

    task automatic do_reset();
        @(negedge tx_clk);
        tx_active = 0; tx_ready = 0; rx_en = 0; rx_data = 0;
        rx_rst_n = 0; tx_rst_n = 0;
        repeat (4) @(negedge rx_clk);
        rx_rst_n = 1; tx_rst_n = 1;
        repeat (2) @(negedge tx_clk);
        got_n = 0; exp_n = 0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge rx_clk);
        rx_en = 1; rx_data = b;
    endtask

    task automatic end_rx();
        @(negedge rx_clk);
        rx_en = 0;
        repeat (2) @(negedge rx_clk);
    endtask

    // alternating preamble of len bits starting with first, then "11"
    task automatic send_pre_sfd(input int len, input logic first);
        for (int i = 0; i < len; i++) send_bit(first ^ logic'(i[0]));
        send_bit(1); send_bit(1);
    endtask

    task automatic send_data(input int n, input int s, input bit stored);
        for (int i = 0; i < n; i++) begin
            send_bit(pat(i, s));
            if (stored && exp_n < DEPTH) begin
                exp_b[exp_n] = pat(i, s);
                exp_n++;
            end
        end
    endtask

    task automatic drain_and_compare(input string req);
        int mism;
        @(negedge tx_clk);
        tx_active = 1; tx_ready = 1;
        repeat (PREMIN + DEPTH + 12) @(negedge tx_clk);
        chk(got_n == exp_n, req, got_n, exp_n);
        mism = 0;
        for (int i = 0; i < exp_n && i < got_n; i++) if (got[i] !== exp_b[i]) mism++;
        chk(mism == 0, req, mism, 0);
        chk(tx_empty === 1'b1 && tx_valid === 1'b0, "R7", int'(tx_empty), 1);
    endtask

    initial begin
        int cyc;
        bit seen;
        do_reset();
        chk(tx_empty === 1'b1, "R1", int'(tx_empty), 1);
        chk(tx_valid === 1'b0, "R1", int'(tx_valid), 0);
        chk(rx_ovf === 1'b0, "R1", int'(rx_ovf), 0);

        // R4 R10 R3: sweep of data lengths 1..DEPTH with two patterns
        for (int n = 1; n <= DEPTH; n++) begin
            for (int s = 3; s <= 5; s += 2) begin
                do_reset();
                send_pre_sfd(8, 1'b1);
                send_data(n, s, 1);
                end_rx();
                drain_and_compare("R4");
                chk(rx_ovf === 1'b0, "R10", int'(rx_ovf), 0);
            end
        end

        // R2 boundary: run of exactly MINRUN accepted (5 bits from 0 + first 1)
        do_reset();
        send_pre_sfd(MINRUN - 1, 1'b0);
        send_data(7, 9, 1);
        end_rx();
        drain_and_compare("R2");

        // R2 boundary: run of MINRUN-1 rejected; trailing zeros give no lock
        do_reset();
        send_pre_sfd(MINRUN - 2, 1'b1);
        for (int i = 0; i < 12; i++) send_bit(0);
        end_rx();
        repeat (8) @(negedge tx_clk);
        chk(tx_empty === 1'b1, "R2", int'(tx_empty), 1);
        drain_and_compare("R3");

        // R5: exact first read edge
        do_reset();
        send_pre_sfd(8, 1'b1);
        send_data(8, 7, 1);
        end_rx();
        repeat (6) @(negedge tx_clk);
        tx_active = 1; tx_ready = 1;
        seen = 0; cyc = 0;
        for (int k = 1; k <= PREMIN + 1; k++) begin
            @(negedge tx_clk);
            if (tx_valid && !seen) begin seen = 1; cyc = k; end
        end
        chk(seen && cyc == PREMIN + 1, "R5", cyc, PREMIN + 1);
        repeat (20) @(negedge tx_clk);
        chk(got_n == 8, "R5", got_n, 8);

        // R6: ready low holds data
        do_reset();
        send_pre_sfd(8, 1'b1);
        send_data(10, 11, 1);
        end_rx();
        tx_active = 1; tx_ready = 0;
        repeat (PREMIN + 30) @(negedge tx_clk);
        chk(got_n == 0, "R6", got_n, 0);
        chk(tx_empty === 1'b0, "R6", int'(tx_empty), 0);
        drain_and_compare("R6");

        // R8: enable drop loses lock, relock appends
        do_reset();
        send_pre_sfd(8, 1'b1);
        send_data(5, 13, 1);
        @(negedge rx_clk); rx_en = 0;
        @(negedge rx_clk);
        for (int i = 0; i < 6; i++) send_bit(1);
        end_rx();
        repeat (8) @(negedge tx_clk);
        tx_active = 1; tx_ready = 1;
        repeat (PREMIN + 20) @(negedge tx_clk);
        chk(got_n == 5, "R8", got_n, 5);
        send_pre_sfd(6, 1'b1);
        send_data(3, 15, 1);
        end_rx();
        repeat (12) @(negedge tx_clk);
        chk(got_n == 8, "R8", got_n, 8);
        begin
            int mm;
            mm = 0;
            for (int i = 0; i < 8; i++) if (got[i] !== exp_b[i]) mm++;
            chk(mm == 0, "R8", mm, 0);
        end

        // R9: overflow
        do_reset();
        send_pre_sfd(8, 1'b1);
        send_data(DEPTH + 5, 17, 1);
        end_rx();
        chk(rx_ovf === 1'b1, "R9", int'(rx_ovf), 1);
        drain_and_compare("R9");
        chk(rx_ovf === 1'b1, "R9", int'(rx_ovf), 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule